// File: doc/BRIEF.md
# Four-Channel Encoder Timestamp Aligner and Skew Accumulator

This block measures the angular skew between the two ends of a rotating shaft. Each end carries one encoder disc that is read by two heads on opposite sides of the disc. For every forward step, each of the four heads delivers a 24-bit timestamp. Each channel's timestamps go into a private queue, so a head that runs ahead of the others never loses data. In any cycle where every queue holds an entry, the block takes the oldest entry from all four queues together and treats them as one matched set.

For each matched set, the block adds the two timestamps from the same end. Adding the opposite heads cancels radial play. It then subtracts the end-B pair sum from the end-A pair sum. The subtraction is taken modulo 2^24 and read as a signed 24-bit number, so timer rollover does no harm. The signed result is added into a 40-bit accumulator. After a fixed number of sets, one revolution's worth, the block presents the total for one cycle and starts again from zero.

A resync input discards everything queued and restarts the revolution. Upstream logic raises it when a decoder detects an index mismatch.

Top module: `shaft_skew_accum`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rev_valid` is 0 and `ovf` is 0000.
- R2: Channel 0 is `ts_a0`, 1 is `ts_a1`, 2 is `ts_b0` and 3 is `ts_b1`. A matched set contributes `d = (a0 + a1 - b0 - b1) mod 2^24`, read as a two's-complement 24-bit value and sign-extended.
- R3: Each channel has a first-in first-out queue of DEPTH (16) entries. One channel may lead the others by up to 16 entries with no loss and without setting its overflow bit, and entries pair up in arrival order.
- R4: A matched set is consumed only in a cycle where all four queues are non-empty. An entry pushed at one clock edge can be consumed at the next edge at the earliest.
- R5: After SETS_PER_REV matched sets, `rev_sum` carries the sum of their contributions and `rev_valid` is high for exactly one cycle. Both appear in the cycle right after the edge that consumed the last set. The next revolution then starts from zero.
- R6: A push into a queue that holds DEPTH entries at that edge is dropped, even if an entry is consumed at the same edge. It sets bit `ovf[i]` for that channel. The bit stays set until reset.
- R7: When `resync` is high at an edge, all four queues are emptied, no set is consumed, pushes at that edge are discarded, and the partial revolution sum and set count go to zero. `ovf` is left unchanged.
- R8: When all four channels push on every cycle, the block consumes one matched set per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_push | input | 4 | Per-channel push strobe, bit i for channel i |
| ts_a0 | input | 24 | Timestamp from end A, head 0 |
| ts_a1 | input | 24 | Timestamp from end A, head 1 |
| ts_b0 | input | 24 | Timestamp from end B, head 0 |
| ts_b1 | input | 24 | Timestamp from end B, head 1 |
| resync | input | 1 | Flush queues and restart the revolution |
| rev_valid | output | 1 | One-cycle strobe marking a completed revolution |
| rev_sum | output | 40 | Signed accumulated skew for the last revolution |
| ovf | output | 4 | Sticky per-channel overflow flags |

## Verification
The hardest state to reach is the one where queue fill levels differ widely. This includes one channel sitting at full depth while the others are empty, a push arriving on the very edge where a full queue drains, and a resync landing in the middle of a revolution with stale entries still queued.

The stimulus drives channels on their own, feeding one channel 16 or 20 times before the others start. It then drains the queues while that channel keeps pushing. A flush is issued while the queues hold unequal leftovers. If any stale entry survived the flush, it would pair up wrongly and change a later revolution total that the scoreboard predicts.

// File: rtl/shaft_skew_accum.sv
module shaft_skew_accum #(
  parameter int TS_W         = 24,
  parameter int DEPTH        = 16,
  parameter int SETS_PER_REV = 8000,
  parameter int ACC_W        = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [3:0]              ts_push,
  input  logic [TS_W-1:0]         ts_a0,
  input  logic [TS_W-1:0]         ts_a1,
  input  logic [TS_W-1:0]         ts_b0,
  input  logic [TS_W-1:0]         ts_b1,
  input  logic                    resync,
  output logic                    rev_valid,
  output logic signed [ACC_W-1:0] rev_sum,
  output logic [3:0]              ovf
);
  localparam int PW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int SCW = $clog2(SETS_PER_REV);

  logic [TS_W-1:0] ts_in [4];
  logic [TS_W-1:0] head  [4];
  logic [3:0]      nonempty, full;
  logic            fire;

  assign ts_in[0] = ts_a0;
  assign ts_in[1] = ts_a1;
  assign ts_in[2] = ts_b0;
  assign ts_in[3] = ts_b1;
  assign fire = (&nonempty) & ~resync;

  for (genvar g = 0; g < 4; g++) begin : g_ch
    logic [TS_W-1:0] mem [DEPTH];
    logic [PW-1:0]   wp, rp;
    logic [CW-1:0]   occ;
    logic            ovf_r;
    logic            wr;

    assign wr          = ts_push[g] & ~full[g] & ~resync;
    assign nonempty[g] = occ != '0;
    assign full[g]     = occ == CW'(DEPTH);
    assign head[g]     = mem[rp];
    assign ovf[g]      = ovf_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp    <= '0;
        rp    <= '0;
        occ   <= '0;
        ovf_r <= 1'b0;
      end else if (resync) begin
        wp  <= '0;
        rp  <= '0;
        occ <= '0;
      end else begin
        if (wr)   wp <= wp + 1'b1;
        if (fire) rp <= rp + 1'b1;
        occ   <= occ + CW'(wr) - CW'(fire);
        ovf_r <= ovf_r | (ts_push[g] & full[g]);
      end
    end

    always_ff @(posedge clk) begin
      if (wr) mem[wp] <= ts_in[g];
    end
  end

  logic [TS_W-1:0]         dmod;
  logic signed [ACC_W-1:0] dext;
  logic signed [ACC_W-1:0] acc;
  logic [SCW-1:0]          setcnt;

  assign dmod = head[0] + head[1] - head[2] - head[3];
  assign dext = {{(ACC_W-TS_W){dmod[TS_W-1]}}, dmod};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      setcnt    <= '0;
      rev_valid <= 1'b0;
      rev_sum   <= '0;
    end else begin
      rev_valid <= 1'b0;
      if (resync) begin
        acc    <= '0;
        setcnt <= '0;
      end else if (fire) begin
        if (setcnt == SCW'(SETS_PER_REV - 1)) begin
          rev_sum   <= acc + dext;
          rev_valid <= 1'b1;
          acc       <= '0;
          setcnt    <= '0;
        end else begin
          acc    <= acc + dext;
          setcnt <= setcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/shaft_skew_accum_chk.sv
module shaft_skew_accum_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ts_push,
  input logic       resync,
  input logic       rev_valid,
  input logic [3:0] ovf,
  input logic [3:0] full,
  input logic       fire
);
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf & $past(ovf)) == $past(ovf)));

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ts_push & full) && !resync) |=> ((ovf & $past(ts_push & full)) == $past(ts_push & full)));

  // R5
  rev_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rev_valid |=> !rev_valid);

  // R5
  rev_after_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rev_valid |-> $past(fire));

  // R7
  resync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !rev_valid);
endmodule

bind shaft_skew_accum shaft_skew_accum_chk u_chk (.*);

// File: tb/shaft_skew_accum_tb.sv
module shaft_skew_accum_tb;
  localparam int SETS = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ts_push = '0;
  logic [23:0] v [4];
  logic        resync = 1'b0;
  logic        rev_valid;
  logic signed [39:0] rev_sum;
  logic [3:0]  ovf;

  always #4 clk = ~clk;

  shaft_skew_accum #(.SETS_PER_REV(SETS)) u_dut (
    .clk(clk), .rst_n(rst_n), .ts_push(ts_push),
    .ts_a0(v[0]), .ts_a1(v[1]), .ts_b0(v[2]), .ts_b1(v[3]),
    .resync(resync), .rev_valid(rev_valid), .rev_sum(rev_sum), .ovf(ovf));

  typedef logic [23:0] q_t [$];
  typedef struct { logic signed [39:0] val; int cyc; } exp_t;
  q_t   mq [4];
  exp_t expq [$];
  logic signed [39:0] m_acc = '0;
  int   m_cnt = 0;
  logic [3:0] exp_ovf = '0;
  int   cyc = 0;
  int   checks = 0, fails = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(input logic [3:0] p, input logic [23:0] x0, input logic [23:0] x1,
                      input logic [23:0] x2, input logic [23:0] x3, input bit rs);
    logic [3:0] fullv;
    bit f;
    logic [23:0] d;
    @(negedge clk);
    ts_push = p; v[0] = x0; v[1] = x1; v[2] = x2; v[3] = x3; resync = rs;
    f = !rs;
    for (int i = 0; i < 4; i++) begin
      fullv[i] = (mq[i].size() == 16);
      if (mq[i].size() == 0) f = 0;
    end
    if (rs) begin
      for (int i = 0; i < 4; i++) mq[i].delete();
      m_acc = '0; m_cnt = 0;
    end else begin
      if (f) begin
        d = mq[0].pop_front() + mq[1].pop_front() - mq[2].pop_front() - mq[3].pop_front();
        m_acc += {{16{d[23]}}, d};
        m_cnt++;
        if (m_cnt == SETS) begin
          expq.push_back('{m_acc, cyc + 1});
          m_acc = '0; m_cnt = 0;
        end
      end
      for (int i = 0; i < 4; i++)
        if (p[i]) begin
          if (fullv[i]) exp_ovf[i] = 1'b1;
          else mq[i].push_back(i == 0 ? x0 : i == 1 ? x1 : i == 2 ? x2 : x3);
        end
    end
  endtask

  function automatic logic [23:0] tsv(input int k, input int ch);
    return 24'((k * 24'h1357) + (ch * 24'h0421) + ((k * k * (ch + 3)) & 24'h3FF));
  endfunction

  always @(negedge clk) begin
    if (rst_n && rev_valid) begin
      if (expq.size() == 0) chk(0, "R5 unexpected rev_valid", 1, 0);
      else begin
        exp_t e;
        e = expq.pop_front();
        chk(rev_sum == e.val, "R2/R5 rev_sum", rev_sum, e.val);
        chk(cyc == e.cyc, "R4/R8 rev_valid timing", cyc, e.cyc);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(4'b0000, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    v[0] = '0; v[1] = '0; v[2] = '0; v[3] = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(rev_valid == 0, "R1 rev_valid in reset", rev_valid, 0);
    chk(ovf == 0, "R1 ovf in reset", ovf, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rev_valid == 0 && ovf == 0, "R1 after reset", {ovf, rev_valid}, 0);

    // R8 / R2: balanced back-to-back streams, two revolutions
    for (int k = 0; k < 2 * SETS; k++)
      step(4'b1111, tsv(k, 0), tsv(k, 1), tsv(k, 2), tsv(k, 3), 0);
    idle(3);

    // R2: timer wraparound and negative differences
    for (int k = 0; k < SETS; k++)
      step(4'b1111, 24'hFFFFF0 + 24'(k), 24'h000010 + 24'(3 * k),
           24'h000008, 24'hFFFF00 + 24'(k * 7), 0);
    idle(3);

    // R3: channel 0 leads by a full queue, no overflow
    for (int k = 0; k < 16; k++) step(4'b0001, tsv(k, 0) ^ 24'h5A5A5A, 0, 0, 0, 0);
    chk(ovf == 4'b0000, "R3 full lead no ovf", ovf, 0);
    for (int k = 0; k < 16; k++) step(4'b1110, 0, tsv(k, 1), tsv(k + 9, 2), tsv(k, 3) ^ 24'h00FF00, 0);
    idle(3);
    chk(ovf == 4'b0000, "R3 lead drained no ovf", ovf, 0);

    // R6: channel 2 overruns by four, then a push on the draining edge of a full queue
    for (int k = 0; k < 20; k++) step(4'b0100, 0, 0, tsv(k, 2) + 24'h123, 0, 0);
    idle(1);
    chk(ovf == 4'b0100, "R6 ovf set ch2", ovf, 4'b0100);
    for (int k = 0; k < 8; k++) step(4'b1111, tsv(k, 0), tsv(k, 1), 24'hABCDEF, tsv(k, 3), 0);
    for (int k = 0; k < 16; k++) step(4'b1011, tsv(k, 0), tsv(k + 5, 1), 0, tsv(k, 3), 0);
    idle(3);
    chk(ovf == exp_ovf, "R6 ovf sticky", ovf, exp_ovf);

    // R7: resync with unequal leftovers mid-revolution
    for (int k = 0; k < 5; k++) step(4'b1111, tsv(k, 3), tsv(k, 2), tsv(k, 1), tsv(k, 0), 0);
    for (int k = 0; k < 3; k++) step(4'b0011, 24'h777777, 24'h111111, 0, 0, 0);
    step(4'b1111, 24'h999999, 24'h999999, 0, 0, 1);
    chk(ovf == exp_ovf, "R7 ovf kept across resync", ovf, exp_ovf);
    for (int k = 0; k < SETS; k++)
      step(4'b1111, tsv(k, 1), tsv(k, 0), tsv(k, 3) + 24'd40, tsv(k, 2), 0);
    idle(3);

    // R4: pairs of staggered pushes
    for (int k = 0; k < SETS; k++) begin
      step(4'b0101, tsv(k, 0), 0, tsv(k, 2), 0, 0);
      step(4'b1010, 0, tsv(k, 1), 0, tsv(k, 3) - 24'd99, 0);
    end
    idle(4);

    // R5: every predicted revolution observed
    chk(expq.size() == 0, "R5 pending revolutions", expq.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule